// File: doc/BRIEF.md
# Per-Grant DMA Word/Byte Transfer Cycle Engine

This block carries out one transfer cycle of a DMA channel each time an arbiter grants it one. For each grant it drives the set of backplane strobes that the target device expects. It makes at most one memory access, a read or a write. When a whole memory word has moved, it updates the channel's working address and negative word count. When the count reaches zero it raises the channel's completion flag.

A byte mode lets a byte-wide device use word-wide memory. On input, two device bytes are combined into one memory word, with the first byte in the upper half. On output, one memory word is split into two device bytes, upper byte first. An 8-bit holding register and an occupied bit carry the odd byte between the two halves, so memory is touched only on every other byte cycle.

A device that does not confirm its I/O phase makes the cycle fail. A failed cycle leaves the address, count and byte state unchanged, so the same grant can simply be retried. Programming of the configuration words and arbitration between channels are handled elsewhere. The engine captures the configuration when `load` pulses.

Top module: `dma_xfer_engine`

## Requirements
- R1: On a cycle that is not the last, an input transfer (cfg_word2 bit 15 = 1) drives dev_ioi and dev_clf, and an output transfer (bit 15 = 0) drives dev_ioo and dev_clf. dev_stc is added when cfg_stc_each is set, and dev_clc and dev_edt stay low. Exactly one of dev_ioi and dev_ioo is high whenever dev_strobe is high.
- R2: A cycle is the last one when the count is 16'hFFFF and the cycle is not the first half of a byte pair. On the last cycle, an input transfer drives dev_ioi and dev_edt with no dev_clf and no dev_stc. An output transfer drives dev_ioo, dev_clf and dev_edt, plus dev_stc when cfg_stc_each is set. In both directions dev_clc is added when cfg_clc_end is set.
- R3: In word mode, an input cycle writes the device word dev_din to memory at the current address (mem_we = 1).
- R4: In word mode, an output cycle first reads memory at the current address and then presents that word on dev_dout during the strobe cycle.
- R5: In byte-input mode, the first half saves dev_din[7:0] and makes no memory access. The second half writes {saved byte, dev_din[7:0]} to memory.
- R6: In byte-output mode, the first half reads memory and presents the upper byte on dev_dout[7:0], with dev_dout[15:8] at zero. The second half presents the saved lower byte and makes no memory access.
- R7: After a successful cycle that is not a first half, cur_addr increments modulo 2^15 and cur_count increments modulo 2^16. After a first half, both hold their values, and the occupied bit toggles on every successful byte cycle.
- R8: When an advance brings the count to zero, enf pulses in that cycle and flag_buf is high from the next cycle. Any grant while flag_buf is high produces no strobe, no memory access and no done pulse.
- R9: When dev_ok is low during the strobe cycle, no memory write occurs, and the address, count and byte state are unchanged, so a repeated grant redoes the same cycle.
- R10: A load pulse captures the configuration, sets cur_addr and cur_count from cfg_word2[14:0] and cfg_word3, and clears flag_buf and the byte state.
- R11: Each accepted grant produces exactly one single-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture configuration and start a new block |
| cfg_stc_each | input | 1 | Add STC on every cycle |
| cfg_pack | input | 1 | Byte packing/unpacking mode |
| cfg_clc_end | input | 1 | Add CLC on the final cycle |
| cfg_sc | input | 6 | Target device select code |
| cfg_word2 | input | 16 | Bit 15 direction (1 = into memory), bits 14:0 start address |
| cfg_word3 | input | 16 | Negative word count |
| grant | input | 1 | Start one cycle (accepted when idle) |
| done | output | 1 | Cycle finished pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ack | input | 1 | Memory access completes this cycle |
| dev_sc | output | 6 | Select code of the device addressed |
| dev_strobe | output | 1 | Device strobe cycle |
| dev_ioi | output | 1 | Input strobe |
| dev_ioo | output | 1 | Output strobe |
| dev_clf | output | 1 | Clear-flag strobe |
| dev_stc | output | 1 | Set-control strobe |
| dev_clc | output | 1 | Clear-control strobe |
| dev_edt | output | 1 | End-of-transfer strobe |
| dev_dout | output | 16 | Data to device |
| dev_din | input | 16 | Data from device |
| dev_ok | input | 1 | Device I/O completed in the strobe cycle |
| cur_addr | output | 15 | Working memory address |
| cur_count | output | 16 | Working negative count |
| flag_buf | output | 1 | Block complete flag |
| enf | output | 1 | Enable-flag pulse on completion |

## Verification
A grant is sampled at a clock edge. The engine spends a fetch cycle when it reads memory and a store cycle when it writes, each lasting until the memory acknowledges. The strobe cycle, with dev_dout valid, comes next or first, depending on direction. done and enf are high in the last cycle, and the updated address, count and flag are visible one cycle after done. The bench records strobes, memory traffic, done and enf at falling edges for the whole cycle, and compares the totals with its own model after done. It reads the register outputs one falling edge after done, when the update has settled.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam int ADDR_W = 15;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int SC_W   = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_IO, S_STORE, S_UPDATE
  } cyc_state_t;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [WORD_W-1:0] count_step(input logic [WORD_W-1:0] c);
    return c + {{(WORD_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic count_is_final(input logic [WORD_W-1:0] c);
    return &c;
  endfunction
endpackage

// File: rtl/dma_xfer_strobes.sv
module dma_xfer_strobes (
  input  logic active,
  input  logic dir_in,
  input  logic stc_each,
  input  logic clc_end,
  input  logic last,
  output logic s_ioi,
  output logic s_ioo,
  output logic s_clf,
  output logic s_stc,
  output logic s_clc,
  output logic s_edt
);
  always_comb begin
    s_ioi = active && dir_in;
    s_ioo = active && !dir_in;
    s_edt = active && last;
    s_clc = active && last && clc_end;
    if (dir_in) begin
      s_clf = active && !last;
      s_stc = active && !last && stc_each;
    end else begin
      s_clf = active;
      s_stc = active && stc_each;
    end
  end
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word2,
  input  logic [WORD_W-1:0] word3,
  input  logic              adv_evt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] count_q,
  output logic              dir_in,
  output logic              flag_q,
  output logic              zero_evt
);
  assign zero_evt = adv_evt && count_is_final(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      dir_in  <= 1'b0;
      flag_q  <= 1'b0;
    end else if (load) begin
      addr_q  <= word2[ADDR_W-1:0];
      count_q <= word3;
      dir_in  <= word2[WORD_W-1];
      flag_q  <= 1'b0;
    end else if (adv_evt) begin
      addr_q  <= addr_step(addr_q);
      count_q <= count_step(count_q);
      if (zero_evt) flag_q <= 1'b1;
    end
  end

  // R7: nothing moves without an advance event
  p_hold_without_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_evt && !load) |=> ($stable(addr_q) && $stable(count_q)));
  // R8: completion leaves zero count and raised flag
  p_enf_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !load) |=> (flag_q && count_q == '0));
endmodule

// File: rtl/dma_xfer_packer.sv
module dma_xfer_packer
  import dma_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd,
  input  logic              dir_in,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [BYTE_W-1:0] out_byte,
  output logic [BYTE_W-1:0] hold_q,
  output logic              occ_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      occ_q  <= 1'b0;
    end else if (clear) begin
      hold_q <= '0;
      occ_q  <= 1'b0;
    end else if (upd) begin
      occ_q <= !occ_q;
      if (!occ_q) hold_q <= dir_in ? in_byte : out_byte;
    end
  end

  // R7: occupied bit flips on every successful byte cycle
  p_occ_toggles_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clear) |=> (occ_q != $past(occ_q)));
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cfg_stc_each,
  input  logic              cfg_pack,
  input  logic              cfg_clc_end,
  input  logic [SC_W-1:0]   cfg_sc,
  input  logic [WORD_W-1:0] cfg_word2,
  input  logic [WORD_W-1:0] cfg_word3,
  input  logic              grant,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [SC_W-1:0]   dev_sc,
  output logic              dev_strobe,
  output logic              dev_ioi,
  output logic              dev_ioo,
  output logic              dev_clf,
  output logic              dev_stc,
  output logic              dev_clc,
  output logic              dev_edt,
  output logic [WORD_W-1:0] dev_dout,
  input  logic [WORD_W-1:0] dev_din,
  input  logic              dev_ok,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_count,
  output logic              flag_buf,
  output logic              enf
);
  localparam int HI_W = WORD_W - BYTE_W;

  cyc_state_t          st_q, st_d;
  logic                stc_q, pack_q, clc_q;
  logic [SC_W-1:0]     sc_q;
  logic [WORD_W-1:0]   rd_q, din_q;
  logic                ok_q;
  logic [BYTE_W-1:0]   hold_q;
  logic                occ_q;
  logic                dir_in;
  logic                first_half, last_cyc, needs_fetch;
  logic                adv_evt, pack_upd, zero_evt, accept;

  assign first_half  = pack_q && !occ_q;
  assign last_cyc    = count_is_final(cur_count) && !first_half;
  assign needs_fetch = !dir_in && !(pack_q && occ_q);
  assign accept      = (st_q == S_IDLE) && grant && !flag_buf;
  assign adv_evt     = (st_q == S_UPDATE) && ok_q && !first_half;
  assign pack_upd    = (st_q == S_UPDATE) && ok_q && pack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stc_q  <= 1'b0;
      pack_q <= 1'b0;
      clc_q  <= 1'b0;
      sc_q   <= '0;
    end else if (load) begin
      stc_q  <= cfg_stc_each;
      pack_q <= cfg_pack;
      clc_q  <= cfg_clc_end;
      sc_q   <= cfg_sc;
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:   if (accept) st_d = needs_fetch ? S_FETCH : S_IO;
      S_FETCH:  if (mem_ack) st_d = S_IO;
      S_IO:     st_d = (dev_ok && dir_in && !first_half) ? S_STORE : S_UPDATE;
      S_STORE:  if (mem_ack) st_d = S_UPDATE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      rd_q  <= '0;
      din_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_FETCH && mem_ack) rd_q <= mem_rdata;
      if (st_q == S_IO) begin
        din_q <= dev_din;
        ok_q  <= dev_ok;
      end
    end
  end

  dma_xfer_regs u_regs (
    .clk(clk), .rst_n(rst_n), .load(load),
    .word2(cfg_word2), .word3(cfg_word3), .adv_evt(adv_evt),
    .addr_q(cur_addr), .count_q(cur_count), .dir_in(dir_in),
    .flag_q(flag_buf), .zero_evt(zero_evt)
  );

  dma_xfer_packer u_packer (
    .clk(clk), .rst_n(rst_n), .clear(load), .upd(pack_upd),
    .dir_in(dir_in), .in_byte(din_q[BYTE_W-1:0]), .out_byte(rd_q[BYTE_W-1:0]),
    .hold_q(hold_q), .occ_q(occ_q)
  );

  dma_xfer_strobes u_strobes (
    .active(st_q == S_IO), .dir_in(dir_in), .stc_each(stc_q),
    .clc_end(clc_q), .last(last_cyc),
    .s_ioi(dev_ioi), .s_ioo(dev_ioo), .s_clf(dev_clf),
    .s_stc(dev_stc), .s_clc(dev_clc), .s_edt(dev_edt)
  );

  assign dev_strobe = (st_q == S_IO);
  assign dev_sc     = sc_q;
  assign mem_req    = (st_q == S_FETCH) || (st_q == S_STORE);
  assign mem_we     = (st_q == S_STORE);
  assign mem_addr   = cur_addr;
  assign mem_wdata  = pack_q ? {hold_q, din_q[BYTE_W-1:0]} : din_q;
  assign done       = (st_q == S_UPDATE);
  assign enf        = zero_evt;

  always_comb begin
    if (!pack_q)        dev_dout = rd_q;
    else if (!occ_q)    dev_dout = {{HI_W{1'b0}}, rd_q[WORD_W-1:WORD_W-BYTE_W]};
    else                dev_dout = {{HI_W{1'b0}}, hold_q};
  end

  // R1: one data direction per strobe cycle
  p_one_direction_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |-> (dev_ioi ^ dev_ioo));
  // R2: final input strobe carries no CLF and no STC
  p_final_input_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_edt && dev_ioi) |-> (!dev_clf && !dev_stc));
  // R6: no memory access for the second half of a byte output
  p_no_fetch_second_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pack_q && occ_q && !dir_in) |=> !mem_req);
  // R8: completed channel stays idle on a grant
  p_flag_blocks_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && flag_buf) |=> (st_q == S_IDLE));
  // R9: a refused device cycle never writes memory
  p_fail_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_strobe && !dev_ok) |=> !mem_we);
  // R11: done lasts a single cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic load = 0, cfg_stc_each = 0, cfg_pack = 0, cfg_clc_end = 0;
  logic [5:0] cfg_sc = 0;
  logic [15:0] cfg_word2 = 0, cfg_word3 = 0;
  logic grant = 0;
  logic done, mem_req, mem_we, mem_ack;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, dev_dout;
  logic [15:0] dev_din = 0;
  logic dev_ok = 1;
  logic [5:0] dev_sc;
  logic dev_strobe, dev_ioi, dev_ioo, dev_clf, dev_stc, dev_clc, dev_edt;
  logic [14:0] cur_addr;
  logic [15:0] cur_count;
  logic flag_buf, enf;

  function automatic logic [15:0] pat(input logic [14:0] a);
    return {a[7:0] ^ 8'h5A, a[14:7]};
  endfunction

  assign mem_ack   = mem_req;
  assign mem_rdata = pat(mem_addr);

  dma_xfer_engine u_dma_xfer_engine (.*);

  int checks = 0, errors = 0;
  int n_strobe, n_rd, n_wr, n_done, n_enf;
  logic [5:0]  seen_set;
  logic [15:0] seen_dout, seen_wdata;
  logic [14:0] seen_waddr;

  always @(negedge clk) begin
    if (dev_strobe) begin
      n_strobe++;
      seen_set  = {dev_ioi, dev_ioo, dev_clf, dev_stc, dev_clc, dev_edt};
      seen_dout = dev_dout;
    end
    if (mem_req && !mem_we) n_rd++;
    if (mem_req && mem_we) begin
      n_wr++; seen_wdata = mem_wdata; seen_waddr = mem_addr;
    end
    if (done) n_done++;
    if (enf) n_enf++;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench model
  logic m_dir, m_pack, m_stc, m_clc, m_occ, m_flag;
  logic [14:0] m_addr;
  logic [15:0] m_cnt;
  logic [7:0]  m_hold;

  task automatic do_load(input logic dir, input logic pk, input logic stc,
                         input logic clc, input logic [14:0] a, input logic [15:0] c);
    @(negedge clk);
    cfg_stc_each = stc; cfg_pack = pk; cfg_clc_end = clc;
    cfg_sc = 6'(a[5:0] | 6'o10);
    cfg_word2 = {dir, a}; cfg_word3 = c; load = 1;
    @(negedge clk);
    load = 0;
    m_dir = dir; m_pack = pk; m_stc = stc; m_clc = clc;
    m_addr = a; m_cnt = c; m_occ = 0; m_hold = 0; m_flag = 0;
    chk("R10", "addr after load", cur_addr, a);
    chk("R10", "count after load", cur_count, c);
    chk("R10", "flag after load", flag_buf, 0);
    chk("R10", "select code", dev_sc, 6'(a[5:0] | 6'o10));
  endtask

  task automatic one_cycle(input logic ok);
    logic first, last;
    logic [5:0] eset;
    logic [15:0] din, edout;
    int guard;
    din = 16'($urandom);
    first = m_pack && !m_occ;
    last  = (m_cnt == 16'hFFFF) && !first;
    if (m_dir) eset = {1'b1, 1'b0, !last, m_stc && !last, m_clc && last, last};
    else       eset = {1'b0, 1'b1, 1'b1, m_stc, m_clc && last, last};
    if (!m_pack)     edout = pat(m_addr);
    else if (first)  edout = {8'h00, pat(m_addr)[15:8]};
    else             edout = {8'h00, m_hold};
    n_strobe = 0; n_rd = 0; n_wr = 0; n_done = 0; n_enf = 0;
    dev_din = din; dev_ok = ok; grant = 1;
    @(negedge clk);
    grant = 0;
    guard = 0;
    while (n_done == 0 && guard < 20) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk("R11", "done pulses", n_done, 1);
    chk("R1", "strobe cycles", n_strobe, 1);
    chk(last ? "R2" : "R1", "strobe set", seen_set, eset);
    if (!m_dir) begin
      chk(m_pack ? "R6" : "R4", "reads", n_rd, (m_pack && m_occ) ? 0 : 1);
      chk(m_pack ? "R6" : "R4", "dev_dout", seen_dout, edout);
    end else if (ok && !first) begin
      chk(m_pack ? "R5" : "R3", "writes", n_wr, 1);
      chk(m_pack ? "R5" : "R3", "write data", seen_wdata, m_pack ? {m_hold, din[7:0]} : din);
      chk("R3", "write addr", seen_waddr, m_addr);
    end else
      chk(ok ? "R5" : "R9", "no write", n_wr, 0);
    if (ok) begin
      if (m_pack) begin
        if (first) m_hold = m_dir ? din[7:0] : pat(m_addr)[7:0];
        m_occ = !m_occ;
      end
      if (!first) begin
        m_addr = m_addr + 15'd1;
        m_cnt  = m_cnt + 16'd1;
        if (m_cnt == 0) m_flag = 1;
      end
    end
    chk(ok ? "R7" : "R9", "addr", cur_addr, m_addr);
    chk(ok ? "R7" : "R9", "count", cur_count, m_cnt);
    chk("R8", "enf pulses", n_enf, (ok && !first && m_cnt == 0) ? 1 : 0);
    chk("R8", "flag", flag_buf, m_flag);
    dev_ok = 1;
  endtask

  task automatic run_block(input logic dir, input logic pk, input logic stc,
                           input logic clc, input logic [14:0] a, input int words, input int fail_pct);
    int guard;
    do_load(dir, pk, stc, clc, a, 16'(-words));
    guard = 0;
    while (!m_flag && guard < 200) begin
      one_cycle(($urandom % 100) >= fail_pct);
      guard++;
    end
    // R8: grant after completion is ignored
    n_strobe = 0; n_rd = 0; n_wr = 0; n_done = 0;
    grant = 1;
    @(negedge clk);
    grant = 0;
    repeat (4) @(negedge clk);
    chk("R8", "ignored grant activity", n_strobe + n_rd + n_wr + n_done, 0);
    chk("R8", "count held", cur_count, 0);
  endtask

  initial begin
    int wd;
    void'($urandom(32'd1234));
    wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10", "reset count", cur_count, 0);
        chk("R10", "reset flag", flag_buf, 0);
        chk("R1", "reset strobe", dev_strobe, 0);
        run_block(1, 0, 1, 1, 15'h0100, 3, 0);
        run_block(0, 0, 0, 1, 15'h0200, 2, 0);
        run_block(1, 1, 1, 0, 15'h0300, 2, 0);
        run_block(0, 1, 1, 1, 15'h0400, 2, 30);
        run_block(1, 0, 0, 0, 15'h7FFE, 3, 20);
        for (int i = 0; i < 30; i++)
          run_block(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    15'($urandom), 1 + int'($urandom % 6), 15);
      end
      begin
        repeat (150000) @(negedge clk);
        wd = 1;
      end
    join_any
    if (wd) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule